// File: doc/BRIEF.md
# PCI 64-bit Initiator Address-Phase Controller

This block sits in the initiator path of a PCI bridge. At the start of each transaction the bridge starts, it decides whether the transaction may ask for the 64-bit extension. It then drives the request-64 strobe for the whole time the transaction's frame is asserted. During the address phases it also drives the upper address half and the upper byte-enable nibble. The transfer engine supplies three things: a one-cycle start pulse, the frame level, and a descriptor for the attempt. The descriptor holds the command, the upper 32 address bits, the byte offset within the cache line, the length in DWORDs, the prefetchable flag, the direction, and what ended the previous attempt.

The peer's 64-bit capability is taken from the level of its request-64 line while reset is held. The value seen on the last reset clock is the one that is kept. A non-zero upper address half selects a dual address cycle. In that case the upper half and the command appear on the extension lanes in both address phases. A zero upper half selects a single address cycle, with zeros on the upper half and a fixed nibble on the upper byte enables.

Top module: `pci64_addr_phase`

## Requirements
- R1: `req64_o` is 1 only while `frame_i` is 1. Within one transaction it keeps the value it had in the start cycle, whatever the descriptor inputs do after that cycle.
- R2: Only the memory read commands (0110, 1100, 1110) and the memory write commands (0111, 1111) may use the extension. Every other command code gives `req64_o`=0. This covers I/O (0010/0011), special cycle (0001) and configuration (1010/1011).
- R3: A memory read with `prefetch_i`=0 gives `req64_o`=0.
- R4: A non-zero `line_off_i[2:0]` (not quadword aligned) gives `req64_o`=0.
- R5: When `line_off_i[4:3]`=11, the last quadword of a 32-byte line, the result is `req64_o`=0.
- R6: A memory read with `len_i`=1 gives `req64_o`=0. A memory write with `len_i` of 1 or 2 also gives `req64_o`=0 (`len_i` is at least 1).
- R7: The capability is the value of `peer_req64_i` on the last clock with `rst_n`=0. When it is 0, an upstream transaction (`upstream_i`=1) gives `req64_o`=0. Downstream transactions are not affected by it.
- R8: Consider a memory write with `resume_i`=1 that follows a disconnect (`prev_retry_i`=0). If `prev_ack64_i`=0, it gives `req64_o`=0. If the earlier ending was a retry, or if the acknowledge had been seen, this rule does not apply.
- R9: A transaction that none of R2 to R8 rules out drives `req64_o`=1 for every cycle of its frame.
- R10: In a 64-bit single address cycle (`addr_hi_i`=0), `hi_oe_o`=1 in the start cycle only. In that cycle `ad_hi_o`=0 and `cbe_hi_o`=1111.
- R11: A non-zero `addr_hi_i` sets `dac_o`=1 in the start cycle and in the cycle after it. In a 64-bit transaction both of those cycles have `hi_oe_o`=1, `ad_hi_o` equal to the upper address and `cbe_hi_o` equal to the command.
- R12: When `hi_oe_o`=0 (32-bit transactions, data cycles, idle and reset), `ad_hi_o` and `cbe_hi_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| peer_req64_i | input | 1 | Peer request-64 level (1 = asserted), sampled during reset |
| start_i | input | 1 | First cycle of a transaction's frame |
| frame_i | input | 1 | Frame asserted (1 = active) |
| cmd_i | input | 4 | Bus command |
| addr_hi_i | input | 32 | Upper address half |
| line_off_i | input | OFF_W (5) | Byte offset within the cache line |
| len_i | input | LEN_W (8) | Transfer length in DWORDs |
| prefetch_i | input | 1 | Target range is prefetchable |
| upstream_i | input | 1 | Transaction goes upstream |
| resume_i | input | 1 | Attempt resumes an earlier terminated one |
| prev_retry_i | input | 1 | Earlier ending was a retry (0 = disconnect) |
| prev_ack64_i | input | 1 | Earlier attempt saw the 64-bit acknowledge |
| req64_o | output | 1 | Request-64 (1 = asserted) |
| dac_o | output | 1 | Dual address cycle address phase in progress |
| hi_oe_o | output | 1 | Extension lanes driven for an address phase |
| ad_hi_o | output | 32 | Upper address lanes |
| cbe_hi_o | output | 4 | Upper byte-enable lanes |

## Verification
The bench resets once with the capability absent and once with it present. This catches a design that samples the capability after release, or that applies it to downstream traffic. Each rule-out is aimed at singly from a transaction that would otherwise qualify. Examples are a write of exactly two DWORDs, an offset at the last line quadword, and a resume after a retry rather than after a disconnect. A design that got the wrong side of one of these boundaries would raise or drop request-64 for that case. Dual-address transactions scramble the descriptor in the second address phase. A design that failed to hold the upper address and command would show the new values, and one that drove the lanes in data cycles would show non-zero lanes.

// File: rtl/pci64_addr_phase.sv
module pci64_addr_phase #(
  parameter int LEN_W = 8,
  parameter int LINE_BYTES = 32,
  parameter logic [3:0] SAC_CBE = 4'hF,
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             peer_req64_i,
  input  logic             start_i,
  input  logic             frame_i,
  input  logic [3:0]       cmd_i,
  input  logic [31:0]      addr_hi_i,
  input  logic [OFF_W-1:0] line_off_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             prefetch_i,
  input  logic             upstream_i,
  input  logic             resume_i,
  input  logic             prev_retry_i,
  input  logic             prev_ack64_i,
  output logic             req64_o,
  output logic             dac_o,
  output logic             hi_oe_o,
  output logic [31:0]      ad_hi_o,
  output logic [3:0]       cbe_hi_o
);
  logic        cap_q, use64_q, dac2_q;
  logic [31:0] ahi_q;
  logic [3:0]  cmd_q;
  logic        is_rd, is_wr, veto, dec64, dac_now, use64, aph;

  assign is_rd   = (cmd_i == 4'h6) || (cmd_i == 4'hC) || (cmd_i == 4'hE);
  assign is_wr   = (cmd_i == 4'h7) || (cmd_i == 4'hF);
  assign veto    = !(is_rd || is_wr)
                 || (is_rd && !prefetch_i)
                 || (|line_off_i[2:0])
                 || (&line_off_i[OFF_W-1:3])
                 || (is_rd && len_i == LEN_W'(1))
                 || (is_wr && len_i <= LEN_W'(2))
                 || (upstream_i && !cap_q)
                 || (is_wr && resume_i && !prev_retry_i && !prev_ack64_i);
  assign dec64   = !veto;
  assign dac_now = |addr_hi_i;

  assign use64   = start_i ? dec64 : use64_q;
  assign req64_o = frame_i && use64;
  assign aph     = start_i || dac2_q;
  assign dac_o   = start_i ? dac_now : dac2_q;
  assign hi_oe_o = req64_o && aph;
  assign ad_hi_o = (hi_oe_o && dac_o) ? (start_i ? addr_hi_i : ahi_q) : 32'h0;
  assign cbe_hi_o = !hi_oe_o ? 4'h0 :
                    !dac_o   ? SAC_CBE :
                    (start_i ? cmd_i : cmd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q   <= peer_req64_i;
      use64_q <= 1'b0;
      dac2_q  <= 1'b0;
      ahi_q   <= 32'h0;
      cmd_q   <= 4'h0;
    end else begin
      if (start_i) begin
        use64_q <= dec64;
        ahi_q   <= addr_hi_i;
        cmd_q   <= cmd_i;
      end else if (!frame_i) begin
        use64_q <= 1'b0;
      end
      dac2_q <= start_i && frame_i && dac_now;
    end
  end
endmodule

module pci64_addr_phase_chk #(
  parameter logic [3:0] SAC_CBE = 4'hF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        frame_i,
  input logic        upstream_i,
  input logic [3:0]  cmd_i,
  input logic        cap_q,
  input logic        req64_o,
  input logic        dac_o,
  input logic        hi_oe_o,
  input logic [31:0] ad_hi_o,
  input logic [3:0]  cbe_hi_o
);
  p_req_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |-> !req64_o);
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i && !start_i && $past(frame_i) && $past(rst_n) |-> req64_o == $past(req64_o));
  p_nonmem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !(cmd_i inside {4'h6, 4'hC, 4'hE, 4'h7, 4'hF}) |-> !req64_o);
  p_upcap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && upstream_i && !cap_q |-> !req64_o);
  p_oe_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_oe_o |-> req64_o);
  p_sac_lanes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_oe_o && !dac_o |-> ad_hi_o == 32'h0 && cbe_hi_o == SAC_CBE);
  p_dac_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hi_oe_o && dac_o && !start_i |-> ad_hi_o == $past(ad_hi_o) && cbe_hi_o == $past(cbe_hi_o));
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_oe_o |-> ad_hi_o == 32'h0 && cbe_hi_o == 4'h0);
endmodule

bind pci64_addr_phase pci64_addr_phase_chk #(.SAC_CBE(SAC_CBE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
  .upstream_i(upstream_i), .cmd_i(cmd_i), .cap_q(cap_q), .req64_o(req64_o),
  .dac_o(dac_o), .hi_oe_o(hi_oe_o), .ad_hi_o(ad_hi_o), .cbe_hi_o(cbe_hi_o));

// File: tb/tb_pci64_addr_phase.sv
`timescale 1ns/1ps
module tb_pci64_addr_phase;
  logic clk = 0, rst_n = 0, peer = 0, start = 0, frame = 0;
  logic [3:0] cmd = 0;
  logic [31:0] ahi = 0;
  logic [4:0] off = 0;
  logic [7:0] len = 1;
  logic pf = 0, up = 0, rs = 0, rt = 0, ak = 0;
  logic req64, dac, oe;
  logic [31:0] adh;
  logic [3:0] cbeh;
  int checks = 0, fails = 0;
  logic cap_m = 0;

  always #2.5 clk = ~clk;

  pci64_addr_phase dut (
    .clk(clk), .rst_n(rst_n), .peer_req64_i(peer), .start_i(start), .frame_i(frame),
    .cmd_i(cmd), .addr_hi_i(ahi), .line_off_i(off), .len_i(len), .prefetch_i(pf),
    .upstream_i(up), .resume_i(rs), .prev_retry_i(rt), .prev_ack64_i(ak),
    .req64_o(req64), .dac_o(dac), .hi_oe_o(oe), .ad_hi_o(adh), .cbe_hi_o(cbeh));

  function automatic bit want64(logic [3:0] c, logic [4:0] o, logic [7:0] n,
                                bit p, bit u, bit r, bit t, bit a, bit cap);
    bit rd = (c == 4'h6 || c == 4'hC || c == 4'hE);
    bit wr = (c == 4'h7 || c == 4'hF);
    if (!rd && !wr) return 0;              // R2
    if (rd && !p) return 0;                // R3
    if (o[2:0] != 0) return 0;             // R4
    if (o[4:3] == 2'b11) return 0;         // R5
    if (rd && n == 1) return 0;            // R6
    if (wr && n <= 2) return 0;            // R6
    if (u && !cap) return 0;               // R7
    if (wr && r && !t && !a) return 0;     // R8
    return 1;                              // R9
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit cap);
    start = 0; frame = 0; rst_n = 0; peer = ~cap;
    repeat (2) @(posedge clk);
    #1 peer = cap;
    @(posedge clk);
    #1 rst_n = 1; peer = ~cap; cap_m = cap;
    @(negedge clk);
    check("R12 reset req64", req64, 0);
    check("R12 reset lanes", {oe, adh, cbeh}, 0);
  endtask

  task automatic txn(string tag, logic [3:0] c, logic [31:0] h, logic [4:0] o,
                     logic [7:0] n, bit p, bit u, bit r, bit t, bit a, int beats);
    bit e = want64(c, o, n, p, u, r, t, a, cap_m);
    bit d = (h != 0);
    @(posedge clk);
    #1 start = 1; frame = 1; cmd = c; ahi = h; off = o; len = n;
    pf = p; up = u; rs = r; rt = t; ak = a;
    @(negedge clk);
    check({tag, " R1/R9 req64 start"}, req64, e);
    check({tag, " R11 dac start"}, dac, d);
    check({tag, " R10 oe start"}, oe, e);
    check({tag, " R10/R11 ad_hi start"}, adh, (e && d) ? h : 0);
    check({tag, " R10/R11 cbe_hi start"}, cbeh, !e ? 0 : (d ? c : 4'hF));
    for (int i = 1; i < beats; i++) begin
      @(posedge clk);
      #1 start = 0; cmd = $urandom; ahi = $urandom; off = $urandom; len = $urandom;
      pf = $urandom; up = $urandom; rs = $urandom; rt = $urandom; ak = $urandom;
      @(negedge clk);
      check({tag, " R1 req64 hold"}, req64, e);
      check({tag, " R11 dac later"}, dac, (i == 1) && d);
      check({tag, " R11/R12 oe later"}, oe, (i == 1) && d && e);
      check({tag, " R11/R12 ad_hi later"}, adh, ((i == 1) && d && e) ? h : 0);
      check({tag, " R11/R12 cbe_hi later"}, cbeh, ((i == 1) && d && e) ? c : 0);
    end
    @(posedge clk);
    #1 start = 0; frame = 0;
    @(negedge clk);
    check({tag, " R1 req64 idle"}, req64, 0);
    check({tag, " R12 idle lanes"}, {oe, adh, cbeh}, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(0);
    txn("R7 up nocap", 4'h7, 0, 0, 4, 1, 1, 0, 0, 0, 3);
    txn("R7 down nocap", 4'h7, 0, 0, 4, 1, 0, 0, 0, 0, 3);
    do_reset(1);
    txn("R7 up cap", 4'h7, 0, 0, 4, 1, 1, 0, 0, 0, 3);
    txn("R9 base", 4'h7, 0, 5'd8, 4, 1, 0, 0, 0, 0, 4);
    txn("R9 prefetch rd", 4'hC, 0, 0, 2, 1, 0, 0, 0, 0, 3);
    txn("R2 io", 4'h3, 0, 0, 4, 1, 0, 0, 0, 0, 2);
    txn("R2 special", 4'h1, 0, 0, 4, 1, 0, 0, 0, 0, 2);
    txn("R2 config", 4'hA, 0, 0, 4, 1, 0, 0, 0, 0, 2);
    txn("R3 nonpf rd", 4'h6, 0, 0, 4, 0, 0, 0, 0, 0, 2);
    txn("R4 misalign", 4'h7, 0, 5'd4, 4, 1, 0, 0, 0, 0, 2);
    txn("R5 line end", 4'hF, 0, 5'd24, 8, 1, 0, 0, 0, 0, 2);
    txn("R5 quad 2", 4'hF, 0, 5'd16, 8, 1, 0, 0, 0, 0, 2);
    txn("R6 rd 1dw", 4'hE, 0, 0, 1, 1, 0, 0, 0, 0, 2);
    txn("R6 wr 2dw", 4'h7, 0, 0, 2, 1, 0, 0, 0, 0, 2);
    txn("R6 wr 3dw", 4'h7, 0, 0, 3, 1, 0, 0, 0, 0, 2);
    txn("R8 disc noack", 4'h7, 0, 0, 4, 1, 0, 1, 0, 0, 2);
    txn("R8 retry noack", 4'h7, 0, 0, 4, 1, 0, 1, 1, 0, 2);
    txn("R8 disc ack", 4'h7, 0, 0, 4, 1, 0, 1, 0, 1, 2);
    txn("R10 sac", 4'h6, 0, 0, 4, 1, 0, 0, 0, 0, 3);
    txn("R11 dac", 4'hF, 32'hDEAD_0001, 0, 6, 1, 0, 0, 0, 0, 4);
    txn("R11 dac 32", 4'h3, 32'h0000_0010, 0, 6, 1, 0, 0, 0, 0, 3);
    for (int k = 0; k < 600; k++) begin
      logic [3:0] c;
      case ($urandom % 8)
        0: c = 4'h6; 1: c = 4'hC; 2: c = 4'hE; 3: c = 4'h7; 4: c = 4'hF;
        default: c = $urandom;
      endcase
      if (k == 300) do_reset($urandom % 2);
      txn("rand", c, ($urandom % 2) ? $urandom : 32'h0, ($urandom % 3 == 0) ? 5'($urandom) : 5'($urandom % 3) << 3,
          8'(1 + $urandom % 6), $urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom % 2,
          $urandom % 2, 2 + $urandom % 3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule